// File: doc/BRIEF.md
# Link Start Speed-Fallback Controller

This controller brings up a serial link in two steps. On a start pulse it first opens write access to fields that are normally read-only. It then reads the link-capabilities register and keeps the maximum-speed field (bits 3:0). It writes the register back with that field set to the lowest rate, 2.5 GT/s, and raises the training enable. Once the link reports up, the controller reads the capabilities register again. If the speed field no longer matches the kept value, it writes the kept value back, sets the speed-change bit of the port-logic control register, and waits for the link to come up a second time.

Every register access goes through one request channel and one read-response channel. The request channel uses valid/ready. Once the request is valid, its address, write flag and write data stay unchanged until ready is seen high on a clock edge. The target may hold ready low for any number of cycles. A read completes when the target pulses the response valid with the data. There is one access in flight at a time, and the response channel cannot be stalled. Each link-up wait has its own cycle limit. On every exit path the controller drops the read-only write access in the same cycle it pulses done, and it reports an error code.

Top module: `link_speed_fallback`

## Requirements
- R1: A start pulse while idle raises busy and read-only write access (`ro_wr_en`). A start pulse while busy is ignored: the run still makes exactly one first capabilities read and gives exactly one done pulse.
- R2: The first access reads the capabilities register at offset CAP_OFF. The second access writes that register back with bits 3:0 equal to 1 (2.5 GT/s) and all other bits unchanged.
- R3: `train_en` rises only after the forced-speed write has been accepted. It stays high until reset.
- R4: If `link_up` is not seen within WAIT1_CYC cycles of training enable, the run ends with `err_code` 1 and makes no further register write.
- R5: After the first link-up the capabilities register is read again. If its bits 3:0 equal the kept value, the run ends with `err_code` 0 after exactly one register write.
- R6: If the bits differ, the controller writes the capabilities register with bits 3:0 restored to the kept value and other bits unchanged. It then reads the port-logic register at PL_OFF and writes it back with bit SPD_BIT (17) set and all other bits unchanged.
- R7: After the speed-change write, `link_up` within WAIT2_CYC cycles ends the run with `err_code` 0. A timeout ends it with `err_code` 2.
- R8: `ro_wr_en` is high during every register write. It is low in the cycle `done` pulses, on success and on both error paths.
- R9: A request stays valid with a stable address, write flag and data until accepted. Stalls on `req_ready` and a delayed `rsp_valid` do not change the result.
- R10: After reset: busy, done, `ro_wr_en`, `train_en` and `req_valid` are low, and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin the bring-up sequence |
| link_up | input | 1 | Link reported up by the training logic |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| err_code | output | 2 | 0 ok, 1 first wait timed out, 2 second wait timed out; held until next start |
| ro_wr_en | output | 1 | Enables writes to read-only register fields |
| train_en | output | 1 | Enables link training |
| req_valid | output | 1 | Register request valid |
| req_ready | input | 1 | Register request accepted |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | ADDR_W | Register offset |
| req_wdata | output | DATA_W | Write data |
| rsp_valid | input | 1 | Read data valid (one-cycle pulse) |
| rsp_data | input | DATA_W | Read data |

## Verification
The bench builds the block with both wait limits at 40 cycles. A link model that never comes up therefore reaches each timeout path quickly, and a link that comes up after 30 cycles tests the case just inside the limit. The register model can toggle ready every cycle and delay read responses, which brings the hold rules of the request channel into play. Different starting speed fields exercise both the skip path and the restore path.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
  typedef enum logic [3:0] {
    SQ_IDLE, SQ_CAP_RD, SQ_CAP_FORCE, SQ_WAIT1, SQ_CAP_RD2,
    SQ_CAP_RESTORE, SQ_PL_RD, SQ_PL_WR, SQ_WAIT2, SQ_FINISH
  } seq_state_e;

  typedef enum logic [1:0] {BA_IDLE, BA_REQ, BA_RESP} bus_state_e;

  typedef enum logic [1:0] {
    LSF_OK = 2'd0, LSF_TMO_FIRST = 2'd1, LSF_TMO_SECOND = 2'd2
  } lsf_err_e;
endpackage

// File: rtl/lsf_wait_timer.sv
module lsf_wait_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/lsf_bus_agent.sv
module lsf_bus_agent
  import lsf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data
);
  bus_state_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= BA_IDLE;
      done      <= 1'b0;
      rdata     <= '0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        BA_IDLE: if (go) begin
          req_valid <= 1'b1;
          req_write <= wr;
          req_addr  <= addr;
          req_wdata <= wdata;
          st        <= BA_REQ;
        end
        BA_REQ: if (req_ready) begin
          req_valid <= 1'b0;
          if (req_write) begin
            done <= 1'b1;
            st   <= BA_IDLE;
          end else begin
            st <= BA_RESP;
          end
        end
        BA_RESP: if (rsp_valid) begin
          rdata <= rsp_data;
          done  <= 1'b1;
          st    <= BA_IDLE;
        end
        default: st <= BA_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsf_sequencer.sv
module lsf_sequencer
  import lsf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SLS_W = 4,
  parameter logic [ADDR_W-1:0] CAP_OFF = 12'h07C,
  parameter logic [ADDR_W-1:0] PL_OFF = 12'h80C,
  parameter int SPD_BIT = 17,
  parameter logic [SLS_W-1:0] FORCE_SLS = 4'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              link_up,
  input  logic              exp1,
  input  logic              exp2,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              go,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              run1,
  output logic              run2,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code,
  output logic              ro_wr_en,
  output logic              train_en
);
  localparam logic [DATA_W-1:0] SPD_MASK = DATA_W'(1) << SPD_BIT;

  seq_state_e      state;
  logic            issued;
  logic            bus_state;
  logic [SLS_W-1:0] saved;

  always_comb begin
    bus_state = 1'b1;
    bus_wr    = 1'b0;
    bus_addr  = CAP_OFF;
    bus_wdata = bus_rdata;
    unique case (state)
      SQ_CAP_RD, SQ_CAP_RD2: ;
      SQ_CAP_FORCE: begin
        bus_wr    = 1'b1;
        bus_wdata = {bus_rdata[DATA_W-1:SLS_W], FORCE_SLS};
      end
      SQ_CAP_RESTORE: begin
        bus_wr    = 1'b1;
        bus_wdata = {bus_rdata[DATA_W-1:SLS_W], saved};
      end
      SQ_PL_RD: bus_addr = PL_OFF;
      SQ_PL_WR: begin
        bus_wr    = 1'b1;
        bus_addr  = PL_OFF;
        bus_wdata = bus_rdata | SPD_MASK;
      end
      default: bus_state = 1'b0;
    endcase
  end

  assign go   = bus_state && !issued;
  assign run1 = (state == SQ_WAIT1);
  assign run2 = (state == SQ_WAIT2);
  assign busy = (state != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      issued   <= 1'b0;
      saved    <= '0;
      done     <= 1'b0;
      err_code <= LSF_OK;
      ro_wr_en <= 1'b0;
      train_en <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) issued <= 1'b1;
      if (bus_done) issued <= 1'b0;
      unique case (state)
        SQ_IDLE: if (start) begin
          ro_wr_en <= 1'b1;
          err_code <= LSF_OK;
          state    <= SQ_CAP_RD;
        end
        SQ_CAP_RD: if (bus_done) begin
          saved <= bus_rdata[SLS_W-1:0];
          state <= SQ_CAP_FORCE;
        end
        SQ_CAP_FORCE: if (bus_done) begin
          train_en <= 1'b1;
          state    <= SQ_WAIT1;
        end
        SQ_WAIT1: begin
          if (link_up) state <= SQ_CAP_RD2;
          else if (exp1) begin
            err_code <= LSF_TMO_FIRST;
            state    <= SQ_FINISH;
          end
        end
        SQ_CAP_RD2: if (bus_done) begin
          if (bus_rdata[SLS_W-1:0] == saved) state <= SQ_FINISH;
          else state <= SQ_CAP_RESTORE;
        end
        SQ_CAP_RESTORE: if (bus_done) state <= SQ_PL_RD;
        SQ_PL_RD: if (bus_done) state <= SQ_PL_WR;
        SQ_PL_WR: if (bus_done) state <= SQ_WAIT2;
        SQ_WAIT2: begin
          if (link_up) state <= SQ_FINISH;
          else if (exp2) begin
            err_code <= LSF_TMO_SECOND;
            state    <= SQ_FINISH;
          end
        end
        SQ_FINISH: begin
          ro_wr_en <= 1'b0;
          done     <= 1'b1;
          state    <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/link_speed_fallback.sv
module link_speed_fallback #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CAP_OFF = 12'h07C,
  parameter logic [ADDR_W-1:0] PL_OFF = 12'h80C,
  parameter int SPD_BIT = 17,
  parameter int WAIT1_CYC = 1000000,
  parameter int WAIT2_CYC = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              link_up,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code,
  output logic              ro_wr_en,
  output logic              train_en,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data
);
  localparam int SLS_W = 4;
  localparam int NWAIT = 2;
  localparam int LIMITS [NWAIT] = '{WAIT1_CYC, WAIT2_CYC};

  logic              go, bus_wr, bus_done;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic [NWAIT-1:0]  run, expired;

  lsf_sequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLS_W(SLS_W),
    .CAP_OFF(CAP_OFF), .PL_OFF(PL_OFF), .SPD_BIT(SPD_BIT),
    .FORCE_SLS(4'd1)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .link_up(link_up),
    .exp1(expired[0]), .exp2(expired[1]),
    .bus_done(bus_done), .bus_rdata(bus_rdata),
    .go(go), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .run1(run[0]), .run2(run[1]),
    .busy(busy), .done(done), .err_code(err_code),
    .ro_wr_en(ro_wr_en), .train_en(train_en)
  );

  lsf_bus_agent #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .go(go), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .done(bus_done), .rdata(bus_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  for (genvar i = 0; i < NWAIT; i++) begin : g_wait
    lsf_wait_timer #(.LIMIT(LIMITS[i])) u_tmr (
      .clk(clk), .rst_n(rst_n), .run(run[i]), .expired(expired[i])
    );
  end
endmodule

// File: rtl/lsf_checker.sv
module lsf_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [1:0]        err_code,
  input logic              ro_wr_en,
  input logic              train_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata
);
  // R9: a stalled request holds its contents
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)
      && $stable(req_wdata) && $stable(req_write));

  // R8: writes only while read-only access is open
  a_r8_write_needs_ro: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |-> ro_wr_en);

  // R8: access closed when the run ends
  a_r8_done_ro_off: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ro_wr_en && !busy);

  // R3: training enable rises inside an open sequence and never falls
  a_r3_train_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_en) |-> ro_wr_en && busy);
  a_r3_train_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    train_en |=> train_en);

  // R10: an idle block issues no requests
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  // R7: error code stays within its defined values
  a_r7_err_legal: assert property (@(posedge clk) disable iff (!rst_n)
    err_code != 2'd3);
endmodule

bind link_speed_fallback lsf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err_code(err_code),
  .ro_wr_en(ro_wr_en), .train_en(train_en), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
  .req_wdata(req_wdata)
);

// File: tb/link_speed_fallback_tb.sv
module link_speed_fallback_tb;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] CAP = 12'h07C;
  localparam logic [ADDR_W-1:0] PL = 12'h80C;
  localparam int TMO = 40;
  localparam logic [15:0] NEVER = 16'd1000;
  localparam logic [31:0] CAP_UP = 32'h0040_A8D0;
  localparam logic [31:0] PL_INIT = 32'h0000_010F;

  typedef struct packed {
    logic [3:0]  sls;
    logic [15:0] d1;
    logic [15:0] d2;
    logic        stall;
    logic [1:0]  err;
    logic [2:0]  wrs;
    logic        plbit;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{4'd3, 16'd5,  16'd7,  1'b0, 2'd0, 3'd3, 1'b1},
    '{4'd1, 16'd5,  16'd7,  1'b0, 2'd0, 3'd1, 1'b0},
    '{4'd2, NEVER,  16'd7,  1'b0, 2'd1, 3'd1, 1'b0},
    '{4'd4, 16'd3,  NEVER,  1'b0, 2'd2, 3'd3, 1'b1},
    '{4'd3, 16'd10, 16'd2,  1'b1, 2'd0, 3'd3, 1'b1},
    '{4'd2, 16'd30, 16'd30, 1'b1, 2'd0, 3'd3, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, link_up;
  logic busy, done, ro_wr_en, train_en, req_valid, req_ready, req_write, rsp_valid;
  logic [1:0] err_code;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata, rsp_data;

  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  link_speed_fallback #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAP_OFF(CAP), .PL_OFF(PL),
    .SPD_BIT(17), .WAIT1_CYC(TMO), .WAIT2_CYC(TMO)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .link_up(link_up),
    .busy(busy), .done(done), .err_code(err_code), .ro_wr_en(ro_wr_en),
    .train_en(train_en), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // register target and link model
  logic [31:0] cap_reg, pl_reg, cap_init, first_wr, pend_data;
  logic [15:0] d1, d2, lcnt;
  logic stall, pend, ph2, first_seen;
  logic [1:0] lat;
  int wr_cnt, cap_rd, bad_wr, hold_bad, done_cnt;
  logic p_stalled;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_wdata;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      cap_reg <= cap_init; pl_reg <= PL_INIT; pend <= 1'b0; lat <= 2'd0;
      rsp_valid <= 1'b0; rsp_data <= '0; req_ready <= 1'b1;
      wr_cnt <= 0; cap_rd <= 0; bad_wr <= 0; hold_bad <= 0; done_cnt <= 0;
      first_seen <= 1'b0; first_wr <= '0; p_stalled <= 1'b0;
      lcnt <= '0; link_up <= 1'b0; ph2 <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (done) done_cnt <= done_cnt + 1;
      if (p_stalled && (!req_valid || req_addr != p_addr || req_wdata != p_wdata))
        hold_bad <= hold_bad + 1;
      p_stalled <= req_valid && !req_ready;
      p_addr <= req_addr; p_wdata <= req_wdata;
      if (pend) begin
        if (lat == 2'd0) begin
          rsp_valid <= 1'b1; rsp_data <= pend_data; pend <= 1'b0;
        end else lat <= lat - 2'd1;
      end
      if (req_valid && req_ready) begin
        if (req_write) begin
          wr_cnt <= wr_cnt + 1;
          if (!ro_wr_en) bad_wr <= bad_wr + 1;
          if (req_addr == CAP) begin
            cap_reg <= req_wdata;
            if (!first_seen) begin first_seen <= 1'b1; first_wr <= req_wdata; end
          end
          if (req_addr == PL) pl_reg <= req_wdata;
        end else begin
          pend <= 1'b1; lat <= stall ? 2'd2 : 2'd0;
          pend_data <= (req_addr == CAP) ? cap_reg : pl_reg;
          if (req_addr == CAP && !first_seen) cap_rd <= cap_rd + 1;
        end
      end
      req_ready <= stall ? ~req_ready : 1'b1;
      if (!train_en) begin
        lcnt <= '0; link_up <= 1'b0;
      end else if (req_valid && req_ready && req_write && req_addr == PL && req_wdata[17]) begin
        ph2 <= 1'b1; lcnt <= '0; link_up <= 1'b0;
      end else begin
        if (lcnt != 16'hFFFF) lcnt <= lcnt + 16'd1;
        link_up <= (lcnt >= (ph2 ? d2 : d1));
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic do_reset(input logic [3:0] sls, input logic [15:0] a, input logic [15:0] b, input logic st);
    rst_n = 1'b0; cap_init = CAP_UP | {28'd0, sls}; d1 = a; d2 = b; stall = st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    int n;
    logic [31:0] exp_cap;
    do_reset(v.sls, v.d1, v.d2, v.stall);
    start = 1'b1; @(negedge clk); start = 1'b0;
    check("R1 busy after start", {31'd0, busy}, 32'd1);
    check("R1 ro_wr_en after start", {31'd0, ro_wr_en}, 32'd1);
    repeat (3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;   // ignored: busy
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) check("R4 run ended", 32'd0, 32'd1);
    check("R8 ro_wr_en low at done", {31'd0, ro_wr_en}, 32'd0);
    check("R4/R5/R7 err_code", {30'd0, err_code}, {30'd0, v.err});
    check("R2 forced write keeps upper bits, rate 1", first_wr, CAP_UP | 32'd1);
    check("R3 train_en held", {31'd0, train_en}, 32'd1);
    exp_cap = CAP_UP | ((v.err == 2'd1) ? 32'd1 : {28'd0, v.sls});
    check("R6 final capabilities", cap_reg, exp_cap);
    check("R6 port-logic speed bit", pl_reg, v.plbit ? (PL_INIT | 32'h0002_0000) : PL_INIT);
    check("R5 write count", wr_cnt, {29'd0, v.wrs});
    check("R8 writes with access open", bad_wr, 0);
    check("R9 request hold", hold_bad, 0);
    repeat (60) @(negedge clk);
    check("R1 one done, idle", {done_cnt[30:0], busy}, {31'd1, 1'b0});
    check("R1 one first read", cap_rd, 1);
  endtask

  initial begin
    cap_init = CAP_UP; d1 = 16'd5; d2 = 16'd5; stall = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 busy", {31'd0, busy}, 0);
    check("R10 done", {31'd0, done}, 0);
    check("R10 ro_wr_en", {31'd0, ro_wr_en}, 0);
    check("R10 train_en", {31'd0, train_en}, 0);
    check("R10 req_valid", {31'd0, req_valid}, 0);
    check("R10 err_code", {30'd0, err_code}, 0);
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);
    // R4 directed: first timeout then a clean restart after reset clears err_code
    do_reset(4'd3, NEVER, 16'd5, 1'b1);
    check("R10 err_code cleared by reset", {30'd0, err_code}, 0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (TMO + 40) @(negedge clk);
    check("R4 timeout code with stalls", {30'd0, err_code}, 32'd1);
    check("R4 no write after timeout", wr_cnt, 1);
    finish_run();
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    finish_run();
  end
endmodule